// File: doc/BRIEF.md
# FIFO Head-Element Address Window Bridge

This block sits between a host or DMA bus port and a CAN controller's message RAM. It reserves four fixed address windows: one for transmit frames, two for receive FIFOs and one for the transmit-event FIFO. An access that falls inside a window goes to the current head element of the matching FIFO. The bridge builds the physical RAM address from that FIFO's base address, the controller's put or get index and the word offset inside the window. An initiator can therefore stream whole frames to fixed addresses and never reads a FIFO pointer.

When the final word of an element moves, the bridge completes the FIFO handshake. A transmit element raises the transmit request bit of its buffer. A receive or event element raises that FIFO's acknowledge, which the controller uses to advance its get index. The bridge also rejects accesses it cannot serve: offsets past the configured element size, reads of an empty FIFO, writes to a full one, and accesses in the wrong direction. Any address outside the four windows is forwarded to the downstream port unchanged.

Top module: `fhw_bridge`

## Requirements
- R1: A host access whose word address is outside every window is forwarded in the same cycle with an unchanged address, direction and write data. Read data returns one cycle later. The window region is a 128-word block at WIN_BASE. The transmit window is at +0, receive FIFO A at +32, receive FIFO B at +64 and the event window at +96. The frame windows span 18 words and the event window spans 3 words. Word slots past a window's span are outside it.
- R2: A write at offset k of the transmit window is sent to RAM word cfg_tx_base + idx*cfg_tx_esize + k. Here idx is the transmit put index.
- R3: In the cycle after the write of offset cfg_tx_esize-1 is granted, tx_req_set has exactly bit idx set for one cycle, where idx is the held put index. At every other time tx_req_set is zero.
- R4: A read at offset k of receive window A or B returns RAM word base + get*esize + k one cycle later. In the cycle after a granted read of offset esize-1, that FIFO's acknowledge is high for one cycle. Other reads raise no acknowledge.
- R5: The event element is 2 words when cfg_evt_stamp is 0 and 3 words when it is 1. The event acknowledge pulses after a granted read of the last of those words.
- R6: The FIFO index is captured on a granted access at offset 0. Offsets 1 and above keep using the captured index, even if the controller index changes during the element.
- R7: An access at an offset at or beyond the element size is not forwarded and a read of it returns zero. win_err is high for one cycle in the next cycle.
- R8: A read while the FIFO is empty, or a transmit write while the transmit FIFO is full, is not forwarded. Such a read returns zero. win_err pulses and no request or acknowledge follows.
- R9: A read of the transmit window, or a write to a receive or event window, is not forwarded, and win_err pulses.
- R10: After reset, tx_req_set, every acknowledge and win_err are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_req | input | 1 | Host access strobe, one word per cycle |
| h_we | input | 1 | Host write (1) or read (0) |
| h_addr | input | AW | Host word address |
| h_wdata | input | DW | Host write data |
| h_rdata | output | DW | Read data, valid the cycle after a read |
| d_req | output | 1 | Downstream access strobe |
| d_we | output | 1 | Downstream write |
| d_addr | output | AW | Downstream word address (translated or forwarded) |
| d_wdata | output | DW | Downstream write data |
| d_rdata | input | DW | Downstream read data, one cycle after d_req |
| cfg_tx_base | input | AW | Transmit buffer area base word |
| cfg_tx_esize | input | 5 | Transmit element size in words (4 to 18) |
| cfg_rx0_base | input | AW | Receive FIFO A base word |
| cfg_rx0_esize | input | 5 | Receive FIFO A element size (4 to 18) |
| cfg_rx1_base | input | AW | Receive FIFO B base word |
| cfg_rx1_esize | input | 5 | Receive FIFO B element size (4 to 18) |
| cfg_evt_base | input | AW | Event FIFO base word |
| cfg_evt_stamp | input | 1 | Event element carries a timestamp word |
| tx_put_idx | input | IDXW | Controller transmit put index |
| tx_full | input | 1 | Transmit FIFO full |
| rx0_get_idx | input | IDXW | Receive FIFO A get index |
| rx0_empty | input | 1 | Receive FIFO A empty |
| rx1_get_idx | input | IDXW | Receive FIFO B get index |
| rx1_empty | input | 1 | Receive FIFO B empty |
| evt_get_idx | input | IDXW | Event FIFO get index |
| evt_empty | input | 1 | Event FIFO empty |
| tx_req_set | output | 2**IDXW | One-cycle transmit request, one bit per buffer |
| rx0_ack | output | 1 | One-cycle acknowledge for receive FIFO A |
| rx1_ack | output | 1 | One-cycle acknowledge for receive FIFO B |
| evt_ack | output | 1 | One-cycle acknowledge for the event FIFO |
| win_err | output | 1 | One-cycle rejected-access flag |

## Verification
The bench builds the bridge with a 10-bit word address, a 3-bit index (eight transmit buffers) and the window region at 0x300. These values let one 1024-word array model the whole RAM. Every word that a window write lands can then be read back through the forwarding path at its computed physical address. Element sizes of 4 and 8 words, indices from 1 to 6, and both event sizes put the last-word detection and the base-plus-index-times-size arithmetic at several distinct points. The event tests use overlapping element layouts, which show that the timestamp setting changes both the stride and the acknowledge position.

// File: rtl/fhw_pkg.sv
// Shared constants and types for the FIFO head-element window bridge.
// Assumes a 128-word window region made of four 32-word slots.
package fhw_pkg;
    localparam int SLOT_W     = 5;   // word-offset bits inside a slot
    localparam int REGION_W   = 7;   // bits spanned by the whole window region
    localparam int SPAN_FRAME = 18;  // words reserved for a frame element
    localparam int SPAN_EVENT = 3;   // words reserved for an event element
    localparam int N_WIN      = 4;

    typedef enum logic [1:0] {
        WIN_TX  = 2'd0,
        WIN_RXA = 2'd1,
        WIN_RXB = 2'd2,
        WIN_EVT = 2'd3
    } win_e;
endpackage

// File: rtl/fhw_decode.sv
// Address decoder: decides whether a host word address falls inside one of
// the four windows. It returns the window and the word offset inside it.
// Assumes WIN_BASE is aligned to the 128-word region.
module fhw_decode
    import fhw_pkg::*;
#(
    parameter int          AW       = 16,
    parameter logic [AW-1:0] WIN_BASE = '1
) (
    input  logic [AW-1:0]     addr,
    output logic              in_win,
    output win_e              sel,
    output logic [SLOT_W-1:0] off
);
    logic region_hit;
    logic [SLOT_W-1:0] span;

    // Split the address into region tag, slot select and offset; check span.
    always_comb begin
        region_hit = (addr[AW-1:REGION_W] == WIN_BASE[AW-1:REGION_W]);
        sel        = win_e'(addr[REGION_W-1:SLOT_W]);
        off        = addr[SLOT_W-1:0];
        span       = (sel == WIN_EVT) ? SLOT_W'(SPAN_EVENT) : SLOT_W'(SPAN_FRAME);
        in_win     = region_hit && (off < span);
    end
endmodule

// File: rtl/fhw_slot.sv
// Per-window context: checks legality of an access, holds the element index
// captured at offset 0, computes the physical RAM address and produces the
// registered completion and error pulses.
// Assumes esize is between 1 and 18 and stays stable during an element.
module fhw_slot
    import fhw_pkg::*;
#(
    parameter int AW     = 16,
    parameter int IDXW   = 5,
    parameter bit DIR_WR = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic              is_write,
    input  logic [SLOT_W-1:0] off,
    input  logic [SLOT_W-1:0] esize,
    input  logic [AW-1:0]     base,
    input  logic [IDXW-1:0]   live_idx,
    input  logic              blocked,
    output logic              grant,
    output logic [AW-1:0]     phys,
    output logic              err_q,
    output logic              done_q,
    output logic [IDXW-1:0]   done_idx
);
    logic            oob;
    logic            wrong_dir;
    logic            first;
    logic            last;
    logic [IDXW-1:0] idx_q;
    logic [IDXW-1:0] use_idx;

    // Legality of the current access and position inside the element.
    always_comb begin
        oob       = (off >= esize);
        wrong_dir = (is_write != DIR_WR);
        grant     = hit && !oob && !wrong_dir && !blocked;
        first     = (off == '0);
        last      = (off == esize - SLOT_W'(1));
        use_idx   = first ? live_idx : idx_q;
        phys      = base + AW'(use_idx) * AW'(esize) + AW'(off);
    end

    // Capture the index on a granted first word; keep it for the element.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_q <= '0;
        else if (grant && first)
            idx_q <= live_idx;
    end

    // One-cycle completion and error pulses, registered after the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            done_idx <= '0;
        end else begin
            done_q   <= grant && last;
            err_q    <= hit && !grant;
            done_idx <= use_idx;
        end
    end

    assert_idx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant && first) |=> $stable(idx_q));

    assert_oob_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && off >= esize) |-> !grant);

    assert_err_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> !done_q);
endmodule

// File: rtl/fhw_bridge.sv
// Top: FIFO head-element window bridge. It decodes host accesses, sends
// window accesses to the current head element of the matching FIFO, forwards
// all other addresses unchanged, and turns last-word transfers into transmit
// requests or FIFO acknowledges.
// Assumes a downstream port with one-cycle read latency and one access per cycle.
module fhw_bridge
    import fhw_pkg::*;
#(
    parameter int            AW       = 16,
    parameter int            DW       = 32,
    parameter int            IDXW     = 5,
    parameter logic [AW-1:0] WIN_BASE = 16'hFF80,
    localparam int           NBUF     = 1 << IDXW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_req,
    input  logic              h_we,
    input  logic [AW-1:0]     h_addr,
    input  logic [DW-1:0]     h_wdata,
    output logic [DW-1:0]     h_rdata,
    output logic              d_req,
    output logic              d_we,
    output logic [AW-1:0]     d_addr,
    output logic [DW-1:0]     d_wdata,
    input  logic [DW-1:0]     d_rdata,
    input  logic [AW-1:0]     cfg_tx_base,
    input  logic [4:0]        cfg_tx_esize,
    input  logic [AW-1:0]     cfg_rx0_base,
    input  logic [4:0]        cfg_rx0_esize,
    input  logic [AW-1:0]     cfg_rx1_base,
    input  logic [4:0]        cfg_rx1_esize,
    input  logic [AW-1:0]     cfg_evt_base,
    input  logic              cfg_evt_stamp,
    input  logic [IDXW-1:0]   tx_put_idx,
    input  logic              tx_full,
    input  logic [IDXW-1:0]   rx0_get_idx,
    input  logic              rx0_empty,
    input  logic [IDXW-1:0]   rx1_get_idx,
    input  logic              rx1_empty,
    input  logic [IDXW-1:0]   evt_get_idx,
    input  logic              evt_empty,
    output logic [NBUF-1:0]   tx_req_set,
    output logic              rx0_ack,
    output logic              rx1_ack,
    output logic              evt_ack,
    output logic              win_err
);
    logic              in_win;
    win_e              sel;
    logic [SLOT_W-1:0] off;

    logic [AW-1:0]     base_a   [N_WIN];
    logic [SLOT_W-1:0] esize_a  [N_WIN];
    logic [IDXW-1:0]   idx_a    [N_WIN];
    logic              block_a  [N_WIN];
    logic [AW-1:0]     phys_a   [N_WIN];
    logic [IDXW-1:0]   didx_a   [N_WIN];
    logic [N_WIN-1:0]  grant_v;
    logic [N_WIN-1:0]  done_v;
    logic [N_WIN-1:0]  err_v;
    logic              zero_rd_q;

    fhw_decode #(.AW(AW), .WIN_BASE(WIN_BASE)) u_decode (
        .addr   (h_addr),
        .in_win (in_win),
        .sel    (sel),
        .off    (off)
    );

    // Collect per-window configuration and controller status into arrays.
    always_comb begin
        base_a[WIN_TX]   = cfg_tx_base;
        base_a[WIN_RXA]  = cfg_rx0_base;
        base_a[WIN_RXB]  = cfg_rx1_base;
        base_a[WIN_EVT]  = cfg_evt_base;
        esize_a[WIN_TX]  = cfg_tx_esize;
        esize_a[WIN_RXA] = cfg_rx0_esize;
        esize_a[WIN_RXB] = cfg_rx1_esize;
        esize_a[WIN_EVT] = cfg_evt_stamp ? SLOT_W'(3) : SLOT_W'(2);
        idx_a[WIN_TX]    = tx_put_idx;
        idx_a[WIN_RXA]   = rx0_get_idx;
        idx_a[WIN_RXB]   = rx1_get_idx;
        idx_a[WIN_EVT]   = evt_get_idx;
        block_a[WIN_TX]  = tx_full;
        block_a[WIN_RXA] = rx0_empty;
        block_a[WIN_RXB] = rx1_empty;
        block_a[WIN_EVT] = evt_empty;
    end

    for (genvar g = 0; g < N_WIN; g++) begin : g_slot
        fhw_slot #(.AW(AW), .IDXW(IDXW), .DIR_WR(g == 0)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .hit      (h_req && in_win && (sel == win_e'(g))),
            .is_write (h_we),
            .off      (off),
            .esize    (esize_a[g]),
            .base     (base_a[g]),
            .live_idx (idx_a[g]),
            .blocked  (block_a[g]),
            .grant    (grant_v[g]),
            .phys     (phys_a[g]),
            .err_q    (err_v[g]),
            .done_q   (done_v[g]),
            .done_idx (didx_a[g])
        );
    end

    // Downstream request: translated inside windows, unchanged outside.
    always_comb begin
        d_req   = h_req && (!in_win || (|grant_v));
        d_we    = h_we;
        d_wdata = h_wdata;
        d_addr  = in_win ? phys_a[sel] : h_addr;
    end

    // Remember reads that were refused so their data returns as zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            zero_rd_q <= 1'b0;
        else
            zero_rd_q <= h_req && !h_we && in_win && !(|grant_v);
    end

    // Return read data and map completion pulses to request/acknowledge outputs.
    always_comb begin
        h_rdata    = zero_rd_q ? '0 : d_rdata;
        tx_req_set = done_v[WIN_TX] ? (NBUF'(1) << didx_a[WIN_TX]) : '0;
        rx0_ack    = done_v[WIN_RXA];
        rx1_ack    = done_v[WIN_RXB];
        evt_ack    = done_v[WIN_EVT];
        win_err    = |err_v;
    end

    assert_fwd_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (h_req && !in_win) |-> (d_req && d_addr == h_addr));

    assert_req_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tx_req_set));
endmodule

// File: tb/fhw_bridge_tb.sv
`timescale 1ns/1ps
module fhw_bridge_tb;
    localparam int AW = 10;
    localparam int DW = 32;
    localparam int IDXW = 3;
    localparam int NBUF = 1 << IDXW;
    localparam logic [AW-1:0] WB = 10'h300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic h_req = 0, h_we = 0;
    logic [AW-1:0] h_addr = '0;
    logic [DW-1:0] h_wdata = '0, h_rdata;
    logic d_req, d_we;
    logic [AW-1:0] d_addr;
    logic [DW-1:0] d_wdata, d_rdata;
    logic [AW-1:0] tx_base = 10'h100, rx0_base = 10'h180, rx1_base = 10'h1C0, evt_base = 10'h200;
    logic [4:0] tx_es = 5'd4, rx0_es = 5'd8, rx1_es = 5'd4;
    logic stamp = 0;
    logic [IDXW-1:0] tx_put = 3'd2, rx0_get = 3'd1, rx1_get = 3'd0, evt_get = 3'd3;
    logic tx_full = 0, rx0_empty = 0, rx1_empty = 0, evt_empty = 0;
    logic [NBUF-1:0] tx_req_set;
    logic rx0_ack, rx1_ack, evt_ack, win_err;

    fhw_bridge #(.AW(AW), .DW(DW), .IDXW(IDXW), .WIN_BASE(WB)) u_dut (
        .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_we(h_we), .h_addr(h_addr),
        .h_wdata(h_wdata), .h_rdata(h_rdata), .d_req(d_req), .d_we(d_we),
        .d_addr(d_addr), .d_wdata(d_wdata), .d_rdata(d_rdata),
        .cfg_tx_base(tx_base), .cfg_tx_esize(tx_es), .cfg_rx0_base(rx0_base),
        .cfg_rx0_esize(rx0_es), .cfg_rx1_base(rx1_base), .cfg_rx1_esize(rx1_es),
        .cfg_evt_base(evt_base), .cfg_evt_stamp(stamp),
        .tx_put_idx(tx_put), .tx_full(tx_full), .rx0_get_idx(rx0_get),
        .rx0_empty(rx0_empty), .rx1_get_idx(rx1_get), .rx1_empty(rx1_empty),
        .evt_get_idx(evt_get), .evt_empty(evt_empty), .tx_req_set(tx_req_set),
        .rx0_ack(rx0_ack), .rx1_ack(rx1_ack), .evt_ack(evt_ack), .win_err(win_err)
    );

    // Downstream RAM model with one-cycle read latency.
    logic [DW-1:0] mem [1 << AW];
    always @(posedge clk) begin
        if (d_req && d_we) mem[d_addr] <= d_wdata;
        if (d_req && !d_we) d_rdata <= mem[d_addr];
    end

    int n_chk = 0, n_bad = 0;
    logic [DW-1:0] exp_q [$];
    string tag_q [$];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pops one expected word for each read and compares the returned data.
    logic mon_pend = 0;
    always @(posedge clk) mon_pend <= h_req && !h_we;
    always @(negedge clk) begin
        if (mon_pend) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL scoreboard: unexpected read data %h expected none", h_rdata);
            end else begin
                check(tag_q.pop_front(), h_rdata, exp_q.pop_front());
            end
        end
    end

    // Driver: one host access, returning at the negedge after the capturing edge.
    task automatic acc(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd);
        @(negedge clk);
        h_req = 1'b1; h_we = we; h_addr = a; h_wdata = wd;
        @(negedge clk);
        h_req = 1'b0; h_we = 1'b0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        acc(1'b1, a, d);
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        acc(1'b0, a, '0);
    endtask

    task automatic chk_pulses(input string tag, input logic [NBUF-1:0] txr,
                              input logic a0, input logic a1, input logic ae, input logic er);
        check({tag, " tx_req_set"}, 32'(tx_req_set), 32'(txr));
        check({tag, " acks"}, {29'd0, rx0_ack, rx1_ack, evt_ack}, {29'd0, a0, a1, ae});
        check({tag, " win_err"}, 32'(win_err), 32'(er));
    endtask

    logic wd_fired = 0;
    initial begin
        #1_000_000;
        wd_fired = 1;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: outputs quiet while and right after reset.
        chk_pulses("R10 reset", '0, 0, 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_pulses("R10 after reset", '0, 0, 0, 0, 0);

        // R1: forwarded accesses below the region and in a slot gap.
        wr(10'h010, 32'hCAFE0010);
        check("R1 fwd no pulse", 32'(win_err), 0);
        rd(10'h010, 32'hCAFE0010, "R1 fwd readback");
        wr(10'h312, 32'h00000312);
        rd(10'h312, 32'h00000312, "R1 slot gap forwarded");

        // R2/R3: transmit element, size 4, put index 2 -> words 0x108..0x10B.
        for (int k = 0; k < 4; k++) begin
            wr(WB + AW'(k), 32'h7000 + k);
            chk_pulses("R3 tx pulse", (k == 3) ? NBUF'(8'b0000_0100) : '0, 0, 0, 0, 0);
        end
        @(negedge clk);
        chk_pulses("R3 single cycle", '0, 0, 0, 0, 0);
        for (int k = 0; k < 4; k++) rd(10'h108 + AW'(k), 32'h7000 + k, "R2 tx landed");

        // R6: put index 3 captured at offset 0, then changes to 6 mid-element.
        tx_put = 3'd3;
        wr(WB, 32'h8000);
        tx_put = 3'd6;
        for (int k = 1; k < 4; k++) begin
            wr(WB + AW'(k), 32'h8000 + k);
            if (k == 3) chk_pulses("R6 req uses held index", NBUF'(8'b0000_1000), 0, 0, 0, 0);
        end
        for (int k = 0; k < 4; k++) rd(10'h10C + AW'(k), 32'h8000 + k, "R6 held index data");
        rd(10'h118, 32'hx, "R6 nothing at live index");

        // R8: write to a full transmit FIFO is refused.
        wr(10'h118, 32'h1111);
        tx_full = 1'b1;
        wr(WB + AW'(3), 32'hBAD0);
        chk_pulses("R8 tx full", '0, 0, 0, 0, 1);
        tx_full = 1'b0;
        rd(10'h118 + AW'(3), 32'hx, "R8 full write dropped");
        tx_put = 3'd6;
        wr(WB, 32'h2222);
        rd(10'h118, 32'h2222, "R2 index 6 offset 0");
        tx_put = 3'd0;

        // R9: read of the transmit window is refused and returns zero.
        rd(WB + AW'(1), 32'h0, "R9 tx window read zero");
        check("R9 tx read err", 32'(win_err), 1);

        // R4: receive FIFO A, size 8, get index 1 -> words 0x188..0x18F.
        for (int k = 0; k < 8; k++) wr(10'h188 + AW'(k), 32'hA0 + k);
        for (int k = 0; k < 8; k++) begin
            rd(WB + 10'd32 + AW'(k), 32'hA0 + k, "R4 rx0 data");
            chk_pulses("R4 rx0 ack", '0, k == 7, 0, 0, 0);
        end

        // R7: offset past element size reads zero and flags an error.
        rd(WB + 10'd32 + 10'd10, 32'h0, "R7 oob read zero");
        chk_pulses("R7 oob err", '0, 0, 0, 0, 1);
        wr(WB + AW'(5), 32'hDEAD);
        chk_pulses("R7 oob write err", '0, 0, 0, 0, 1);
        rd(10'h100 + AW'(5), 32'hx, "R7 oob write not stored");

        // R9: write into receive window A is refused, RAM unchanged.
        wr(WB + 10'd32, 32'hBEEF);
        chk_pulses("R9 rx write err", '0, 0, 0, 0, 1);
        rd(10'h188, 32'hA0, "R9 rx ram unchanged");

        // R8: receive FIFO B empty: zero data, error, no acknowledge.
        wr(10'h1C0, 32'h5555);
        rx1_empty = 1'b1;
        rd(WB + 10'd64, 32'h0, "R8 rx1 empty zero");
        chk_pulses("R8 rx1 empty", '0, 0, 0, 0, 1);
        rx1_empty = 1'b0;
        rd(WB + 10'd64, 32'h5555, "R4 rx1 data");

        // R5: event FIFO, words 0x206..0x208 prefilled.
        for (int k = 0; k < 3; k++) wr(10'h206 + AW'(k), 32'hE0 + k);
        stamp = 1'b0; evt_get = 3'd3;
        rd(WB + 10'd96, 32'hE0, "R5 evt2 word0");
        chk_pulses("R5 evt2 no ack", '0, 0, 0, 0, 0);
        rd(WB + 10'd97, 32'hE1, "R5 evt2 word1");
        chk_pulses("R5 evt2 ack", '0, 0, 0, 1, 0);
        rd(WB + 10'd98, 32'h0, "R5 evt2 third word refused");
        chk_pulses("R5 evt2 oob", '0, 0, 0, 0, 1);
        stamp = 1'b1; evt_get = 3'd2;
        for (int k = 0; k < 3; k++) begin
            rd(WB + 10'd96 + AW'(k), 32'hE0 + k, "R5 evt3 data");
            chk_pulses("R5 evt3 ack", '0, 0, 0, k == 2, 0);
        end

        repeat (3) @(negedge clk);
        if (!wd_fired) begin
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule